// File: doc/BRIEF.md
# Split-Halfword GPIO Controller

This block is a GPIO controller for a configurable number of pins (32 by default). Software sees each 32-bit state vector as two 16-bit halves. The vectors are the driven outputs, the sampled inputs, the two edge-arming masks and the latched interrupt status. The lower half of each vector sits at a base offset, and the upper half sits at the same offset plus 0x500. A write to one half changes only that half. A read returns the chosen half right-aligned, with the upper bits cleared.

Each input pin passes through a sampling register, and its sampled value is compared with the previous sample. A 0→1 change latches the pin's status bit when the pin is armed in the rising mask. A 1→0 change latches it when the pin is armed in the falling mask. Any latched status bit holds the single interrupt line high. Software clears status bits by writing ones.

The controller also drives side outputs taken from specific output bits. Bits 18:16 feed a three-bit brightness field, which a dedicated register can also write and read. Bits 29 and 30 drive the data and clock lines of a bit-banged I2C bus.

Top module: `hgpio_ctrl`

## Requirements
- R1: After reset, both input halves (0x010, 0x510) read 0xFFFF. The output, mask, status and brightness registers read 0. The irq, brightness, I2C data and I2C clock outputs are 0.
- R2: The register offsets are: output 0x00C/0x50C, input 0x010/0x510, falling mask 0x014/0x514, rising mask 0x018/0x518, status 0x020/0x520. A low-half write replaces bits 15:0 and keeps bits 31:16. A high-half write loads wdata[15:0] into bits 31:16. A read returns the selected half in rdata[15:0], with rdata[31:16] zero, in the cycle after rd_en.
- R3: pins_out shows the full output register in the cycle after the write.
- R4: When a pin goes 0→1, its status bit is set if its rising-mask bit is 1 and is not set if that bit is 0.
- R5: When a pin goes 1→0, its status bit is set if its falling-mask bit is 1 and is not set if that bit is 0.
- R6: Driving a pin to the level it already holds sets no status bit.
- R7: Writing 1 to a status bit in either half clears that bit. A 0 in the written value, or a write to the other half, leaves the bit unchanged.
- R8: irq is 1 exactly when at least one status bit is 1. It rises in the same cycle the status bit latches and falls in the cycle after the clearing write.
- R9: If an edge sets a status bit in the same cycle that a write-one clears it, the bit stays 1. Other bits cleared by the same write still clear.
- R10: i2c_sda follows output bit 29 and i2c_scl follows output bit 30. Both change only on a high-half output write (wdata[13] and wdata[14]).
- R11: A high-half output write loads brightness from output bits 18:16 (wdata[2:0]). A write to 0x508 loads brightness from wdata[2:0]. A read of 0x508 returns it, and the last write of either kind wins.
- R12: A write to an unmapped offset has no effect, and a read from one returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Register byte offset |
| wdata | input | 32 | Write data; halves use bits 15:0 |
| rdata | output | 32 | Read data, registered |
| pins_in | input | 32 | Input pin levels |
| pins_out | output | 32 | Output register value |
| irq | output | 1 | Interrupt, high while any status bit is set |
| bright | output | 3 | Brightness field |
| i2c_sda | output | 1 | Bit-banged I2C data |
| i2c_scl | output | 1 | Bit-banged I2C clock |

## Verification
An edge latch and a software write-one-clear can land on the same status bit in the same cycle. The bench provokes this by changing an armed pin, then timing the clearing write so it takes effect at the very edge where the sampled change latches. The same clearing write also targets a second, already-latched bit. The result is judged by reading status afterwards: the edge-hit bit must survive, the other bit must clear, and irq must stay high.

// File: rtl/hgpio_pkg.sv
package hgpio_pkg;

  localparam int unsigned ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFS_OUT  = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_IN   = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_FEN  = 12'h014;
  localparam logic [ADDR_W-1:0] OFS_REN  = 12'h018;
  localparam logic [ADDR_W-1:0] OFS_STS  = 12'h020;
  localparam logic [ADDR_W-1:0] HI_STEP  = 12'h500;
  localparam logic [ADDR_W-1:0] OFS_BRT  = 12'h508;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_OUT,
    SEL_IN,
    SEL_FEN,
    SEL_REN,
    SEL_STS,
    SEL_BRT
  } sel_e;

  typedef struct packed {
    sel_e sel;
    logic hi;
  } dec_t;

  function automatic dec_t decode(input logic [ADDR_W-1:0] a);
    dec_t d;
    d.sel = SEL_NONE;
    d.hi  = 1'b0;
    case (a)
      OFS_OUT:           d.sel = SEL_OUT;
      OFS_IN:            d.sel = SEL_IN;
      OFS_FEN:           d.sel = SEL_FEN;
      OFS_REN:           d.sel = SEL_REN;
      OFS_STS:           d.sel = SEL_STS;
      OFS_OUT + HI_STEP: begin d.sel = SEL_OUT; d.hi = 1'b1; end
      OFS_IN  + HI_STEP: begin d.sel = SEL_IN;  d.hi = 1'b1; end
      OFS_FEN + HI_STEP: begin d.sel = SEL_FEN; d.hi = 1'b1; end
      OFS_REN + HI_STEP: begin d.sel = SEL_REN; d.hi = 1'b1; end
      OFS_STS + HI_STEP: begin d.sel = SEL_STS; d.hi = 1'b1; end
      OFS_BRT:           d.sel = SEL_BRT;
      default:           d.sel = SEL_NONE;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/hgpio_halfreg.sv
module hgpio_halfreg #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] RST = '0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_lo,
  input  logic           wr_hi,
  input  logic [W/2-1:0] wdata,
  output logic [W-1:0]   q
);
  localparam int unsigned H = W / 2;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= RST;
    end else begin
      if (wr_lo) q[H-1:0] <= wdata;
      if (wr_hi) q[W-1:H] <= wdata;
    end
  end
endmodule

// File: rtl/hgpio_edge.sv
module hgpio_edge #(
  parameter int unsigned W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   pins_in,
  input  logic [W-1:0]   fall_en,
  input  logic [W-1:0]   rise_en,
  input  logic           clr_lo,
  input  logic           clr_hi,
  input  logic [W/2-1:0] clr_data,
  output logic [W-1:0]   in_q,
  output logic [W-1:0]   status,
  output logic [W-1:0]   set_vec,
  output logic           irq
);
  localparam int unsigned H = W / 2;

  logic [W-1:0] prev_q;
  logic [W-1:0] clr_mask;
  logic [W-1:0] status_nx;

  // Sample the pins, then keep the previous sample for comparison.
  always_ff @(posedge clk) begin
    if (rst) begin
      in_q   <= '1;
      prev_q <= '1;
    end else begin
      in_q   <= pins_in;
      prev_q <= in_q;
    end
  end

  always_comb begin
    set_vec  = (in_q & ~prev_q & rise_en) | (~in_q & prev_q & fall_en);
    clr_mask = {(clr_hi ? clr_data : {H{1'b0}}),
                (clr_lo ? clr_data : {H{1'b0}})};
    // A new edge outranks a clear in the same cycle.
    status_nx = (status & ~clr_mask) | set_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      irq    <= 1'b0;
    end else begin
      status <= status_nx;
      irq    <= |status_nx;
    end
  end
endmodule

// File: rtl/hgpio_side.sv
module hgpio_side #(
  parameter int unsigned W       = 32,
  parameter int unsigned BRT_LSB = 16,
  parameter int unsigned BRT_W   = 3,
  parameter int unsigned SDA_BIT = 29,
  parameter int unsigned SCL_BIT = 30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_brt,
  input  logic             wr_out_hi,
  input  logic [W/2-1:0]   wdata,
  output logic [BRT_W-1:0] bright,
  output logic             sda,
  output logic             scl
);
  localparam int unsigned H = W / 2;
  localparam int unsigned BRT_OFS = BRT_LSB - H;
  localparam int unsigned SDA_OFS = SDA_BIT - H;
  localparam int unsigned SCL_OFS = SCL_BIT - H;

  always_ff @(posedge clk) begin
    if (rst) begin
      bright <= '0;
      sda    <= 1'b0;
      scl    <= 1'b0;
    end else if (wr_out_hi) begin
      bright <= wdata[BRT_OFS +: BRT_W];
      sda    <= wdata[SDA_OFS];
      scl    <= wdata[SCL_OFS];
    end else if (wr_brt) begin
      bright <= wdata[BRT_W-1:0];
    end
  end
endmodule

// File: rtl/hgpio_ctrl.sv
module hgpio_ctrl #(
  parameter int unsigned NPINS   = 32,
  parameter int unsigned BRT_LSB = 16,
  parameter int unsigned BRT_W   = 3,
  parameter int unsigned SDA_BIT = 29,
  parameter int unsigned SCL_BIT = 30
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [hgpio_pkg::ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]         wdata,
  output logic [NPINS-1:0]         rdata,
  input  logic [NPINS-1:0]         pins_in,
  output logic [NPINS-1:0]         pins_out,
  output logic                     irq,
  output logic [BRT_W-1:0]         bright,
  output logic                     i2c_sda,
  output logic                     i2c_scl
);
  import hgpio_pkg::*;

  localparam int unsigned H     = NPINS / 2;
  localparam int unsigned N_CFG = 3;

  dec_t dec;
  logic [NPINS-1:0] cfg_q [N_CFG];
  logic [NPINS-1:0] in_q;
  logic [NPINS-1:0] sts_q;
  logic [NPINS-1:0] set_w;
  logic [H-1:0]     rd_half;
  logic             unused_wdata;

  assign dec          = decode(addr);
  assign unused_wdata = ^wdata[NPINS-1:H];

  // Output, falling mask and rising mask share one split-half register shape.
  for (genvar g = 0; g < N_CFG; g++) begin : g_cfg
    localparam sel_e SEL_G = (g == 0) ? SEL_OUT : ((g == 1) ? SEL_FEN : SEL_REN);
    hgpio_halfreg #(.W(NPINS), .RST('0)) u_reg (
      .clk   (clk),
      .rst   (rst),
      .wr_lo (wr_en && dec.sel == SEL_G && !dec.hi),
      .wr_hi (wr_en && dec.sel == SEL_G &&  dec.hi),
      .wdata (wdata[H-1:0]),
      .q     (cfg_q[g])
    );
  end

  hgpio_edge #(.W(NPINS)) u_edge (
    .clk      (clk),
    .rst      (rst),
    .pins_in  (pins_in),
    .fall_en  (cfg_q[1]),
    .rise_en  (cfg_q[2]),
    .clr_lo   (wr_en && dec.sel == SEL_STS && !dec.hi),
    .clr_hi   (wr_en && dec.sel == SEL_STS &&  dec.hi),
    .clr_data (wdata[H-1:0]),
    .in_q     (in_q),
    .status   (sts_q),
    .set_vec  (set_w),
    .irq      (irq)
  );

  hgpio_side #(
    .W       (NPINS),
    .BRT_LSB (BRT_LSB),
    .BRT_W   (BRT_W),
    .SDA_BIT (SDA_BIT),
    .SCL_BIT (SCL_BIT)
  ) u_side (
    .clk       (clk),
    .rst       (rst),
    .wr_brt    (wr_en && dec.sel == SEL_BRT),
    .wr_out_hi (wr_en && dec.sel == SEL_OUT && dec.hi),
    .wdata     (wdata[H-1:0]),
    .bright    (bright),
    .sda       (i2c_sda),
    .scl       (i2c_scl)
  );

  assign pins_out = cfg_q[0];

  always_comb begin
    rd_half = '0;
    case (dec.sel)
      SEL_OUT: rd_half = dec.hi ? cfg_q[0][NPINS-1:H] : cfg_q[0][H-1:0];
      SEL_IN:  rd_half = dec.hi ? in_q[NPINS-1:H]     : in_q[H-1:0];
      SEL_FEN: rd_half = dec.hi ? cfg_q[1][NPINS-1:H] : cfg_q[1][H-1:0];
      SEL_REN: rd_half = dec.hi ? cfg_q[2][NPINS-1:H] : cfg_q[2][H-1:0];
      SEL_STS: rd_half = dec.hi ? sts_q[NPINS-1:H]    : sts_q[H-1:0];
      SEL_BRT: rd_half[BRT_W-1:0] = bright;
      default: rd_half = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= {{(NPINS-H){1'b0}}, rd_half};
    end
  end
endmodule

// File: rtl/hgpio_ctrl_chk.sv
module hgpio_ctrl_chk #(
  parameter int unsigned W = 32
) (
  input logic           clk,
  input logic           rst,
  input logic           wr_en,
  input logic [11:0]    addr,
  input logic [W/2-1:0] wdata,
  input logic           irq,
  input logic [2:0]     bright,
  input logic           i2c_sda,
  input logic           i2c_scl,
  input logic [W-1:0]   status,
  input logic [W-1:0]   set_vec
);
  // R1: outputs are quiet right after reset
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq && bright == 3'd0 && !i2c_sda && !i2c_scl));

  // R8: the interrupt line reflects the status vector
  a_r8_irq_status: assert property (@(posedge clk) disable iff (rst)
    irq == (status != '0));

  // R6: a status bit only appears where an armed edge was seen
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (rst)
    (status & ~$past(status) & ~$past(set_vec)) == '0);

  // R9: an edge always lands, whatever the write did in that cycle
  a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> ((status & $past(set_vec)) == $past(set_vec)));

  // R7: write-one on low status bit 0 clears it when no edge competes
  a_r7_clear_bit0: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 12'h020 && wdata[0] && !set_vec[0]) |=> !status[0]);

  // R10: I2C lines move only after a high-half output write
  a_r10_side_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en && addr == 12'h50C) |-> ($stable(i2c_sda) && $stable(i2c_scl)));
endmodule

bind hgpio_ctrl hgpio_ctrl_chk #(.W(NPINS)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .addr    (addr),
  .wdata   (wdata[NPINS/2-1:0]),
  .irq     (irq),
  .bright  (bright),
  .i2c_sda (i2c_sda),
  .i2c_scl (i2c_scl),
  .status  (sts_q),
  .set_vec (set_w)
);

// File: tb/test_hgpio_ctrl.sv
module test_hgpio_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pins_in = 32'hFFFF_FFFF;
  logic [31:0] pins_out;
  logic        irq;
  logic [2:0]  bright;
  logic        i2c_sda;
  logic        i2c_scl;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  hgpio_ctrl i_hgpio_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pins_in(pins_in), .pins_out(pins_out),
    .irq(irq), .bright(bright), .i2c_sda(i2c_sda), .i2c_scl(i2c_scl)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Driver: issue a read and push its expected value to the scoreboard.
  task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pins(logic [31:0] v);
    @(negedge clk);
    pins_in = v;
    repeat (3) @(negedge clk);
  endtask

  // Monitor: pop the expected value once the registered read data appears.
  initial begin
    forever begin
      @(posedge clk);
      if (rd_en && !rst) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          check("scoreboard underflow", rdata, 32'hx);
        end else begin
          check(tag_q.pop_front(), rdata, exp_q.pop_front());
        end
      end
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 bright", {29'd0, bright}, 32'd0);
    check("R1 i2c", {30'd0, i2c_sda, i2c_scl}, 32'd0);
    check("R1 pins_out", pins_out, 32'd0);
    rd(12'h010, 32'h0000_FFFF, "R1 in lo");
    rd(12'h510, 32'h0000_FFFF, "R1 in hi");
    rd(12'h00C, 32'h0, "R1 out lo");
    rd(12'h020, 32'h0, "R1 status lo");
    rd(12'h518, 32'h0, "R1 rise hi");
    rd(12'h508, 32'h0, "R1 brightness");

    // R2/R3 split-half access
    wr(12'h00C, 32'h1234_ABCD);
    wr(12'h50C, 32'hFFFF_5678);
    @(negedge clk);
    check("R3 pins_out", pins_out, 32'h5678_ABCD);
    check("R10 i2c after 5678", {30'd0, i2c_sda, i2c_scl}, 32'd1);
    rd(12'h00C, 32'h0000_ABCD, "R2 out lo");
    rd(12'h50C, 32'h0000_5678, "R2 out hi");
    wr(12'h00C, 32'h0000_1111);
    rd(12'h50C, 32'h0000_5678, "R2 hi kept");
    rd(12'h00C, 32'h0000_1111, "R2 lo replaced");

    // R10/R11 side outputs
    wr(12'h50C, 32'h0000_2005);
    @(negedge clk);
    check("R10 i2c after 2005", {30'd0, i2c_sda, i2c_scl}, 32'd2);
    check("R11 bright from out", {29'd0, bright}, 32'd5);
    check("R3 pins_out 2", pins_out, 32'h2005_1111);
    rd(12'h508, 32'h5, "R11 read brightness");
    wr(12'h508, 32'hFFFF_FFF3);
    @(negedge clk);
    check("R11 bright direct", {29'd0, bright}, 32'd3);
    check("R10 sda held", {31'd0, i2c_sda}, 32'd1);
    check("R3 pins_out unchanged", pins_out, 32'h2005_1111);
    rd(12'h508, 32'h3, "R11 read brightness 2");
    wr(12'h00C, 32'h0000_6000);
    @(negedge clk);
    check("R10 low write no effect", {30'd0, i2c_sda, i2c_scl}, 32'd2);

    // R12 unmapped
    wr(12'h004, 32'hFFFF_FFFF);
    rd(12'h004, 32'h0, "R12 unmapped read");
    rd(12'h024, 32'h0, "R12 unmapped read 2");
    rd(12'h00C, 32'h0000_6000, "R12 out untouched");
    check("R12 pins_out", pins_out, 32'h2005_6000);

    // Arm: rising on pins 0,1; falling on pin 16
    wr(12'h018, 32'h0000_0003);
    wr(12'h514, 32'h0000_0001);
    rd(12'h018, 32'h3, "R2 rise lo");

    // R5 negative / R4 positive
    pins(32'hFFFF_FFFE);
    check("R5 unarmed fall irq", {31'd0, irq}, 32'd0);
    rd(12'h020, 32'h0, "R5 unarmed fall status");
    pins(32'hFFFF_FFFF);
    check("R8 irq on rise", {31'd0, irq}, 32'd1);
    rd(12'h020, 32'h1, "R4 rise pin0");
    rd(12'h010, 32'hFFFF, "R2 in lo");
    // R4 negative: unarmed pin 2 rising
    pins(32'hFFFF_FFFB);
    pins(32'hFFFF_FFFF);
    rd(12'h020, 32'h1, "R4 unarmed rise pin2");

    // R7 clear, R8 irq drops
    wr(12'h020, 32'h0000_0001);
    @(negedge clk);
    check("R8 irq after clear", {31'd0, irq}, 32'd0);
    rd(12'h020, 32'h0, "R7 cleared lo");

    // R6 re-drive held level
    pins(32'hFFFF_FFFF);
    check("R6 irq", {31'd0, irq}, 32'd0);
    rd(12'h020, 32'h0, "R6 status lo");

    // R5 falling on armed pin 16
    pins(32'hFFFE_FFFF);
    check("R5 irq", {31'd0, irq}, 32'd1);
    rd(12'h520, 32'h1, "R5 status hi");
    rd(12'h020, 32'h0, "R5 status lo");
    rd(12'h510, 32'hFFFE, "R2 in hi");
    wr(12'h520, 32'h0000_0000);
    rd(12'h520, 32'h1, "R7 zero write keeps");
    wr(12'h020, 32'h0000_0001);
    rd(12'h520, 32'h1, "R7 other half keeps");
    wr(12'h520, 32'h0000_0001);
    rd(12'h520, 32'h0, "R7 clear hi");
    pins(32'hFFFF_FFFF);
    rd(12'h520, 32'h0, "R4 unarmed rise pin16");

    // Two armed pins rise together
    pins(32'hFFFF_FFFC);
    pins(32'hFFFF_FFFF);
    rd(12'h020, 32'h3, "R4 two pins");
    wr(12'h020, 32'h0000_0001);
    rd(12'h020, 32'h2, "R7 partial clear");

    // R9: edge on pin0 latches at the same edge as a clear of bits 0 and 1
    pins(32'hFFFF_FFFE);
    @(negedge clk);
    pins_in = 32'hFFFF_FFFF;
    @(negedge clk);
    wr_en = 1'b1; addr = 12'h020; wdata = 32'h0000_0003;
    @(negedge clk);
    wr_en = 1'b0;
    check("R9 irq stays", {31'd0, irq}, 32'd1);
    rd(12'h020, 32'h1, "R9 set wins");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) check("scoreboard drained", exp_q.size(), 0);
    summary();
  end
endmodule